// File: doc/BRIEF.md
# Two-Stage Serial-to-Parallel Word Demultiplexer

This block turns one serial bit stream, delivered with its own bit clock, into 32-bit parallel words plus a word clock running at one thirty-second of the bit rate. The conversion runs in two steps. A quarter-rate stage gathers the stream four bits at a time, so that four lanes each carry every fourth bit. Each lane then shifts into its own 8-bit register. Once all lane registers have taken eight new bits, the 32 bits move together into the output word.

Two input pairs, each made of a data bit and its clock, feed the block: a normal pair and a loopback pair. A low-active select picks between them. The select passes through a glitch-free clock switch, so the divider chain never sees a runt pulse. The load pulse for the output word is free-running and is not tied to any frame marker. The word boundary is therefore set by where the divider happens to sit, not by the data. Frame and byte alignment belong to the logic downstream.

Top module: `split_deser32`

## Requirements
- R1: While rst_n is low, dout reads all zeros and word_clk reads 0.
- R2: With loop_n high, each new dout value is 32 consecutive bits of din_main sampled on rising clk_main edges. The earliest of those bits is on dout[31] and the latest on dout[0].
- R3: With loop_n low, dout is built the same way from din_loop on rising clk_loop edges, and din_main has no effect on it.
- R4: Successive words are contiguous. Each word begins with the bit that follows the last bit of the word before it, so within one mode no bit is dropped or repeated.
- R5: dout changes only on the load pulse. The pulse fires once every 32 selected bit-clock edges, so dout holds each word for 32 bit clocks.
- R6: word_clk is the selected bit clock divided by 32, high for 16 bit clocks and low for 16.
- R7: A change of loop_n gates off the old clock before it enables the new one, so the two clocks are never passed through together. The first word made only of new-source bits reaches dout within 80 bit clocks of the change. Words captured during the change may be corrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_main | input | 1 | Bit clock of the normal input |
| din_main | input | 1 | Serial data of the normal input |
| clk_loop | input | 1 | Bit clock of the loopback input |
| din_loop | input | 1 | Serial data of the loopback input |
| loop_n | input | 1 | Source select: 0 picks loopback, 1 picks normal |
| dout | output | 32 | Parallel word, earliest bit at bit 31 |
| word_clk | output | 1 | Selected bit clock divided by 32 |

## Verification
A lane fed the wrong bit, or a swapped lane-to-output mapping, shows at the very first loaded word. That word then matches no window of the input stream, and the mismatch appears within about 40 bit clocks of reset. A slip in the quarter-rate counter or the lane counter breaks the contiguity between two neighbouring words, or moves the load spacing away from 32. Either shows one word later. A fault in the clock switch shows as a wrong source or a missing word after a change of loop_n, well inside the 80-clock limit.

// File: rtl/split_deser32.sv
module split_deser32 #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    rst_n,
  input  logic                    clk_main,
  input  logic                    din_main,
  input  logic                    clk_loop,
  input  logic                    din_loop,
  input  logic                    loop_n,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    word_clk
);
  localparam int W  = LANES * LANE_W;
  localparam int PW = $clog2(LANES);
  localparam int SW = $clog2(LANE_W);
  localparam int CW = $clog2(W);

  // glitch-free source switch: enable changes only while its clock is low
  logic m_s1, m_en, l_s1, l_en;

  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) m_s1 <= 1'b0;
    else        m_s1 <= loop_n & ~l_en;

  always_ff @(negedge clk_main or negedge rst_n)
    if (!rst_n) m_en <= 1'b0;
    else        m_en <= m_s1;

  always_ff @(posedge clk_loop or negedge rst_n)
    if (!rst_n) l_s1 <= 1'b0;
    else        l_s1 <= ~loop_n & ~m_en;

  always_ff @(negedge clk_loop or negedge rst_n)
    if (!rst_n) l_en <= 1'b0;
    else        l_en <= l_s1;

  wire bit_clk = (clk_main & m_en) | (clk_loop & l_en);
  wire din     = m_en ? din_main : din_loop;

  // quarter-rate stage
  logic [PW-1:0]    ph;
  logic [LANES-2:0] pre;
  logic [LANES-1:0] quad;
  logic             q_v;
  wire  [LANES-1:0] quad_nx = {pre, din};
  wire              last    = (ph == PW'(LANES - 1));

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      ph   <= '0;
      pre  <= '0;
      quad <= '0;
      q_v  <= 1'b0;
    end else begin
      ph  <= ph + 1'b1;
      pre <= quad_nx[LANES-2:0];
      q_v <= last;
      if (last) quad <= quad_nx;
    end

  // lane shift registers and free-running load count
  logic [SW-1:0]     scnt;
  logic [LANE_W-2:0] sr    [LANES];
  logic [LANE_W-1:0] sr_nx [LANES];
  logic [W-1:0]      word_nx;
  wire               ld = q_v & (scnt == SW'(LANE_W - 1));

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)   scnt <= '0;
    else if (q_v) scnt <= scnt + 1'b1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sr_nx[k] = {sr[k], quad[LANES-1-k]};

    always_ff @(posedge bit_clk or negedge rst_n)
      if (!rst_n)   sr[k] <= '0;
      else if (q_v) sr[k] <= sr_nx[k][LANE_W-2:0];

    for (genvar m = 0; m < LANE_W; m++) begin : g_bit
      assign word_nx[m*LANES + (LANES-1-k)] = sr_nx[k][m];
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)  dout <= '0;
    else if (ld) dout <= word_nx;

  assign word_clk = scnt[SW-1];

  // assertions
  logic [CW-1:0] ld_gap;
  logic          ld_seen;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      ld_gap  <= '0;
      ld_seen <= 1'b0;
    end else if (ld) begin
      ld_gap  <= '0;
      ld_seen <= 1'b1;
    end else begin
      ld_gap  <= ld_gap + 1'b1;
    end

  p_src_excl_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
    $onehot0({m_en, l_en}));

  p_main_off_r3: assert property (@(posedge clk_main) disable iff (!rst_n)
    (!loop_n && !$past(loop_n)) |-> !m_en);

  p_loop_off_r2: assert property (@(posedge clk_loop) disable iff (!rst_n)
    (loop_n && $past(loop_n)) |-> !l_en);

  p_hold_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !ld |=> $stable(dout));

  p_ld_spacing_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (ld && ld_seen) |-> (ld_gap == CW'(W - 1)));
endmodule

// File: tb/tb_split_deser32.sv
`timescale 1ns/1ps
module tb_split_deser32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic din_main = 1'b0, din_loop = 1'b0, loop_n = 1'b1;
  logic [31:0] dout;
  logic        word_clk;

  always #2.5 clk = ~clk;

  split_deser32 dut (
    .rst_n(rst_n), .clk_main(clk), .din_main(din_main),
    .clk_loop(clk), .din_loop(din_loop), .loop_n(loop_n),
    .dout(dout), .word_clk(word_clk)
  );

  localparam int MAXB = 8192;
  logic hm [MAXB];
  logic hl [MAXB];
  int n = 0, checks = 0, errors = 0;
  int pat = 0;
  bit cur_lp = 0, synced = 0, switching = 0, wc_seen = 0;
  int last_e = 0, since_chg = 0, since_sw = 0, settle = 0, wc_cnt = 0;
  logic [31:0] prev = '0;
  logic        wc_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] win(input int e, input bit lp);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = lp ? hl[e-31+i] : hm[e-31+i];
    return w;
  endfunction

  task automatic observe();
    logic [31:0] ex;
    bit found;
    since_chg++;
    wc_cnt++;
    if (word_clk !== wc_prev) begin
      if (wc_seen && settle == 0) chk(wc_cnt == 16, "R6 half period", wc_cnt, 16);
      wc_seen = 1; wc_cnt = 0; wc_prev = word_clk;
    end
    if (dout !== prev) begin
      if (synced) begin
        ex = win(last_e + 32, cur_lp);
        chk(dout === ex, cur_lp ? "R3 R4 loop word" : "R2 R4 word", dout, ex);
        chk(since_chg == 32, "R5 load spacing", since_chg, 32);
        last_e += 32;
        if (cur_lp) begin
          ex = win(last_e, 0);
          chk(dout !== ex, "R3 main leaked", dout, ~ex);
        end
      end else begin
        found = 0;
        for (int e = n - 1; e >= 31 && e >= n - 96 && !found; e--)
          if (win(e, cur_lp) === dout) begin found = 1; last_e = e; end
        if (!switching) chk(found, "R2 first word", dout, win(n - 1, cur_lp));
        if (found) begin
          synced = 1;
          if (switching) begin
            chk(since_sw <= 80, "R7 switch time", since_sw, 80);
            switching = 0;
          end
        end
      end
      since_chg = 0;
      prev = dout;
    end
    if (switching) begin
      since_sw++;
      if (since_sw > 80) begin
        chk(0, "R7 no new-source word", dout, 0);
        switching = 0;
      end
    end
    if (settle > 0) settle--;
  endtask

  task automatic step();
    logic b;
    @(negedge clk);
    #1;
    observe();
    case (pat)
      1:       b = (n % 7 == 0);
      2:       b = ((n / 5) % 2 == 1);
      default: b = 1'($urandom);
    endcase
    din_main = b;
    din_loop = 1'($urandom);
    hm[n] = din_main;
    hl[n] = din_loop;
    n++;
  endtask

  task automatic switch_to(input bit lp);
    loop_n = ~lp;
    cur_lp = lp;
    synced = 0; switching = 1; since_sw = 0;
    settle = 100; wc_seen = 0;
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk(dout === 32'h0 && word_clk === 1'b0, "R1 reset", dout, 32'h0);
    end
    rst_n = 1'b1;
    pat = 0; repeat (600) step();
    pat = 1; repeat (300) step();
    pat = 2; repeat (300) step();
    pat = 0; switch_to(1); repeat (800) step();
    switch_to(0); repeat (500) step();
    pat = 1; repeat (200) step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule